// File: doc/BRIEF.md
# Strobed Parallel Word Capture

This block pulls a packet of words from an external device over a parallel data bus that it always treats as an input. For each word it drives one strobe cycle on a control line toward the device and latches the bus at one of two selectable points in that cycle. Captured words go into a two-entry double buffer. A consumer empties the buffer through a valid/ready read port.

A start pulse launches a packet whose length comes from an 8-bit count. Three configuration bits set the following: the polarity of the strobe's active phase, the level the control line rests at outside strobe cycles, and the sample point. The sample point is either the return edge of the strobe or the end of the strobe cycle. If the consumer keeps up, strobe cycles follow one another with no gap for the whole packet. If both buffer entries are taken when a new cycle would begin, the block waits and holds the control line at its rest level until an entry frees. A one-clock done pulse marks the capture of the final word. Configuration must stay stable while a packet runs.

Top module: `pstrobe_rx`

## Requirements
- R1: During and straight after a synchronous reset, the control line sits at the rest level `cfg_idle_lvl`, `rd_valid` is 0 and `done` is 0.
- R2: A strobe cycle is four clocks long: one inactive clock, two active clocks, then one inactive clock. The active level is 1 when `cfg_pol`=1 and 0 when `cfg_pol`=0. The inactive level is the opposite of the active level.
- R3: When the buffer has room, the first active clock of a packet comes two clocks after the clock edge that samples `start`. Later cycles follow back to back, with exactly two inactive clocks between active pairs. A packet of N words produces exactly N strobe cycles.
- R4: With `cfg_ret_smp`=1, the stored word is the bus value at the clock edge that ends the second active clock, which is the edge where the strobe returns.
- R5: With `cfg_ret_smp`=0, the stored word is the bus value at the clock edge that ends the fourth clock of the strobe cycle.
- R6: If launching a new cycle would leave no free entry at its sample point, no new cycle starts. Strobing resumes once the consumer frees an entry, and no word is lost.
- R7: Outside strobe cycles the control line is at `cfg_idle_lvl`. This covers idle time and stall waits.
- R8: Words leave in capture order. `rd_valid` is high while the buffer holds a word. When `rd_valid` is high and `rd_ready` is low, `rd_data` holds steady. A read and a write may happen in the same clock.
- R9: `done` is high for exactly one clock, the clock right after the edge that stores the last word of the packet.
- R10: A `start` is ignored while a packet is in progress, and a `start` with `cfg_len`=0 is ignored. Neither produces strobe cycles or a `done` pulse.
- R11: The buffer never takes a write while both entries are full. The consumer receives exactly N words per packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Pulse that begins a packet |
| cfg_len | input | LW (8) | Words per packet |
| cfg_pol | input | 1 | Active level of the strobe (1 = high) |
| cfg_idle_lvl | input | 1 | Control line level outside strobe cycles |
| cfg_ret_smp | input | 1 | 1 = sample on the return edge, 0 = sample at the end of the cycle |
| bus_in | input | DW (16) | Parallel data from the device |
| strb_out | output | 1 | Control strobe to the device |
| rd_data | output | DW (16) | Oldest buffered word |
| rd_valid | output | 1 | Buffer holds a word |
| rd_ready | input | 1 | Consumer takes the word this clock |
| done | output | 1 | Last word of the packet stored |

## Verification
The bench samples all outputs on the falling edge, so every result is counted in whole clocks from the rising edge that caused it. The strobe shows its first inactive clock one edge after `start` is sampled and its first active clock one edge later. A word sampled on the return edge is visible on `rd_valid` in the half-clock right after that edge. A word sampled at the end of the cycle appears one clock later. `done` rises on the same falling-edge sample where the final word first becomes readable. The bench model keeps the bus value that was present at each edge and picks the expected word by counting strobe clocks, using the active and inactive runs it observes, rather than looking inside the block.

// File: rtl/pstrobe_pkg.sv
package pstrobe_pkg;

  // Phase of the capture sequencer. LEAD/ACT0/ACT1/TAIL form one strobe cycle.
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_WAIT = 3'd1,
    PH_LEAD = 3'd2,
    PH_ACT0 = 3'd3,
    PH_ACT1 = 3'd4,
    PH_TAIL = 3'd5
  } ph_e;

  // True when the buffer will still have a free entry after this clock's traffic.
  function automatic logic f_room(int occ, logic wr, logic rd, int depth);
    int nxt;
    nxt = occ + (wr ? 1 : 0) - (rd ? 1 : 0);
    return nxt < depth;
  endfunction

  function automatic logic f_in_cycle(ph_e ph);
    return (ph == PH_LEAD) || (ph == PH_ACT0) || (ph == PH_ACT1) || (ph == PH_TAIL);
  endfunction

  function automatic logic f_is_active(ph_e ph);
    return (ph == PH_ACT0) || (ph == PH_ACT1);
  endfunction

  // Control line level for a phase, polarity and rest level.
  function automatic logic f_line(ph_e ph, logic pol, logic idle_lvl);
    logic lvl;
    if (!f_in_cycle(ph))      lvl = idle_lvl;
    else if (f_is_active(ph)) lvl = pol;
    else                      lvl = ~pol;
    return lvl;
  endfunction

  // Phase whose closing edge latches the bus for the chosen sample point.
  function automatic logic f_sample(ph_e ph, logic ret_smp);
    return ret_smp ? (ph == PH_ACT1) : (ph == PH_TAIL);
  endfunction

endpackage

// File: rtl/pstrobe_seq.sv
module pstrobe_seq
  import pstrobe_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] len,
  input  logic          ret_smp,
  input  logic          room,
  output ph_e           ph,
  output logic          wr_fire,
  output logic          done
);

  ph_e           ph_d;
  logic [LW-1:0] left_q, left_d;
  logic          accept;
  logic          launch;

  assign accept  = (ph == PH_IDLE) && start && (len != '0);
  assign wr_fire = f_sample(ph, ret_smp);

  always_comb begin
    ph_d   = ph;
    launch = 1'b0;
    case (ph)
      PH_IDLE: begin
        if (accept) begin
          if (room) begin
            ph_d   = PH_LEAD;
            launch = 1'b1;
          end else begin
            ph_d = PH_WAIT;
          end
        end
      end
      PH_WAIT: begin
        if (room) begin
          ph_d   = PH_LEAD;
          launch = 1'b1;
        end
      end
      PH_LEAD: ph_d = PH_ACT0;
      PH_ACT0: ph_d = PH_ACT1;
      PH_ACT1: ph_d = PH_TAIL;
      PH_TAIL: begin
        if (left_q == '0) begin
          ph_d = PH_IDLE;
        end else if (room) begin
          ph_d   = PH_LEAD;
          launch = 1'b1;
        end else begin
          ph_d = PH_WAIT;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  // Cycles still to launch in this packet.
  always_comb begin
    left_d = left_q;
    if (accept)      left_d = len - {{(LW-1){1'b0}}, launch};
    else if (launch) left_d = left_q - {{(LW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      ph     <= ph_d;
      left_q <= left_d;
      done   <= wr_fire && (left_q == '0);
    end
  end

endmodule

// File: rtl/pstrobe_dbuf.sv
module pstrobe_dbuf #(
  parameter int DW    = 16,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [DW-1:0]                wr_data,
  input  logic                         rd_en,
  output logic [DW-1:0]                rd_data,
  output logic                         rd_valid,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);

  logic [DW-1:0] slot [DEPTH];
  logic [PW-1:0] wptr, rptr;

  function automatic logic [PW-1:0] f_step(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wptr == PW'(i))) slot[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (wr_en) wptr <= f_step(wptr);
      if (rd_en) rptr <= f_step(rptr);
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + OW'(1);
        2'b01:   occ <= occ - OW'(1);
        default: occ <= occ;
      endcase
    end
  end

  assign rd_data  = slot[rptr];
  assign rd_valid = (occ != '0);

endmodule

// File: rtl/pstrobe_drv.sv
module pstrobe_drv
  import pstrobe_pkg::*;
(
  input  ph_e  ph,
  input  logic pol,
  input  logic idle_lvl,
  output logic strb
);

  assign strb = f_line(ph, pol, idle_lvl);

endmodule

// File: rtl/pstrobe_rx.sv
module pstrobe_rx
  import pstrobe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] cfg_len,
  input  logic          cfg_pol,
  input  logic          cfg_idle_lvl,
  input  logic          cfg_ret_smp,
  input  logic [DW-1:0] bus_in,
  output logic          strb_out,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic          done
);

  localparam int OW = $clog2(DEPTH + 1);

  ph_e           ph;
  logic          wr_fire;
  logic          rd_fire;
  logic          room;
  logic [OW-1:0] occ;

  assign rd_fire = rd_valid && rd_ready;
  assign room    = f_room(int'(occ), wr_fire, rd_fire, DEPTH);

  pstrobe_seq #(.LW(LW)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .len     (cfg_len),
    .ret_smp (cfg_ret_smp),
    .room    (room),
    .ph      (ph),
    .wr_fire (wr_fire),
    .done    (done)
  );

  pstrobe_dbuf #(.DW(DW), .DEPTH(DEPTH)) u_dbuf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_fire),
    .wr_data  (bus_in),
    .rd_en    (rd_fire),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .occ      (occ)
  );

  pstrobe_drv u_drv (
    .ph       (ph),
    .pol      (cfg_pol),
    .idle_lvl (cfg_idle_lvl),
    .strb     (strb_out)
  );

endmodule

// File: rtl/pstrobe_rx_chk.sv
module pstrobe_rx_chk
  import pstrobe_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 2,
  parameter int OW    = 2
) (
  input logic          clk,
  input logic          rst,
  input ph_e           ph,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [OW-1:0] occ,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [DW-1:0] rd_data,
  input logic          done,
  input logic          strb_out,
  input logic          cfg_idle_lvl
);

  // R11: a write never lands on a full buffer unless a read frees a slot.
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> ((int'(occ) < DEPTH) || rd_fire));

  // R2: the active phase always spans two clocks.
  p_act_pair_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_ACT0) |=> (ph == PH_ACT1));

  // R6: while waiting for room, the line rests at the rest level.
  p_stall_level_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_WAIT) |-> (strb_out == cfg_idle_lvl));

  // R8: an offered word stays put until it is taken.
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R9: done lasts one clock.
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: done only follows a buffer write.
  p_done_after_wr_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(wr_fire));

endmodule

bind pstrobe_rx pstrobe_rx_chk #(.DW(DW), .DEPTH(DEPTH), .OW(OW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .ph           (ph),
  .wr_fire      (wr_fire),
  .rd_fire      (rd_fire),
  .occ          (occ),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_data      (rd_data),
  .done         (done),
  .strb_out     (strb_out),
  .cfg_idle_lvl (cfg_idle_lvl)
);

// File: tb/pstrobe_rx_bench.sv
`timescale 1ns/1ps
module pstrobe_rx_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  cfg_len = 8'd0;
  logic        cfg_pol = 1'b0;
  logic        cfg_idle_lvl = 1'b1;
  logic        cfg_ret_smp = 1'b0;
  logic [15:0] bus_in = 16'h0;
  logic        strb_out;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic        done;

  always #2 clk = ~clk;

  pstrobe_rx u_pstrobe_rx (
    .clk (clk), .rst (rst), .start (start), .cfg_len (cfg_len),
    .cfg_pol (cfg_pol), .cfg_idle_lvl (cfg_idle_lvl), .cfg_ret_smp (cfg_ret_smp),
    .bus_in (bus_in), .strb_out (strb_out), .rd_data (rd_data),
    .rd_valid (rd_valid), .rd_ready (rd_ready), .done (done)
  );

  int n_chk = 0, n_err = 0, tick = 0;
  int rmode = 0, cur_len = 0;
  int pushed = 0, got = 0, dones = 0, act_cycles = 0, act_run = 0, gap_run = 0;
  int start_tick = 0, first_act_tick = 0;
  logic mon_en = 1'b0, prev_act = 1'b0, pend = 1'b0, seen_act = 1'b0, gap_check = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(logic ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Expected line level at clock i after start in the stall scenario (rest level = active level).
  function automatic logic f_stall_line(int i, logic pol, logic idle_lvl);
    if (i >= 8) return idle_lvl;
    return ((i % 4) == 1 || (i % 4) == 2) ? pol : ~pol;
  endfunction

  // Monitor, reference model and consumer, all on the falling edge.
  always @(negedge clk) begin
    logic act;
    logic rdy;
    logic [15:0] e;
    tick++;
    if (tick > 150000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", tick, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
    if (!rst && mon_en) begin
      act = (strb_out == cfg_pol);
      if (pend) begin exp_q.push_back(bus_in); pushed++; pend = 1'b0; end
      if (prev_act && !act) begin
        chk(act_run == 2, "R2 active run", act_run, 2);
        act_cycles++;
        gap_run = 0;
        if (cfg_ret_smp) begin exp_q.push_back(bus_in); pushed++; end
        else pend = 1'b1;
      end
      if (act) begin
        if (!seen_act) first_act_tick = tick;
        if (!prev_act && seen_act && gap_check) chk(gap_run == 2, "R3 gap", gap_run, 2);
        act_run = prev_act ? act_run + 1 : 1;
        seen_act = 1'b1;
      end else begin
        gap_run++;
      end
      prev_act = act;
    end
    if (!rst && done) begin
      dones++;
      if (mon_en) chk(pushed == cur_len, "R9 done timing", pushed, cur_len);
    end
    rdy = (rmode == 1) ? 1'b1 : (rmode == 2) ? 1'($urandom % 2) : 1'b0;
    rd_ready = rdy;
    if (!rst && rd_valid && rdy) begin
      got++;
      if (mon_en) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 read of nothing", int'(rd_data), -1);
        else begin
          e = exp_q.pop_front();
          chk(rd_data == e, cfg_ret_smp ? "R4 R8 word" : "R5 R8 word", int'(rd_data), int'(e));
        end
      end
    end
    bus_in = 16'($urandom);
  end

  task automatic run_pkt(int len, logic ret, logic pol, int mode, logic gchk, int restart_at);
    int w;
    @(posedge clk); #1;
    cfg_len = 8'(len); cfg_ret_smp = ret; cfg_pol = pol; cfg_idle_lvl = ~pol;
    rmode = mode; cur_len = len; pushed = 0; got = 0; dones = 0; act_cycles = 0;
    seen_act = 1'b0; prev_act = 1'b0; pend = 1'b0; gap_check = gchk; exp_q.delete();
    mon_en = 1'b1;
    @(posedge clk); #1;
    start = 1'b1; start_tick = tick;
    @(posedge clk); #1;
    start = 1'b0;
    w = 0;
    while ((got < len || dones == 0) && w < 3000) begin
      start = (w == restart_at);
      @(posedge clk); #1;
      w++;
    end
    start = 1'b0;
    repeat (12) @(posedge clk); #1;
    chk(got == len, "R11 words delivered", got, len);
    chk(dones == 1, "R9 done count", dones, 1);
    chk(act_cycles == len, "R3 cycle count", act_cycles, len);
    chk(exp_q.size() == 0, "R8 leftover", exp_q.size(), 0);
    chk(strb_out == ~pol, "R7 rest level after packet", int'(strb_out), int'(~pol));
    if (gchk) chk(first_act_tick - start_tick == 3, "R3 first strobe", first_act_tick - start_tick, 3);
  endtask

  task automatic stall_test(logic ret, logic pol);
    int bad, w;
    @(posedge clk); #1;
    cfg_len = 8'd5; cfg_ret_smp = ret; cfg_pol = pol; cfg_idle_lvl = pol;
    mon_en = 1'b0; rmode = 0; got = 0; dones = 0;
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (strb_out !== f_stall_line(i, pol, pol)) bad++;
    end
    chk(bad == 0, "R6 R7 stall waveform", bad, 0);
    chk(rd_valid == 1'b1, "R6 buffer holds words", int'(rd_valid), 1);
    chk(dones == 0, "R6 no done while stalled", dones, 0);
    @(posedge clk); #1;
    rmode = 2;
    w = 0;
    while ((got < 5 || dones == 0) && w < 3000) begin @(posedge clk); #1; w++; end
    repeat (10) @(posedge clk); #1;
    chk(got == 5, "R6 resume without loss", got, 5);
    chk(dones == 1, "R9 done after stall", dones, 1);
    chk(strb_out == pol, "R7 rest level", int'(strb_out), int'(pol));
    rmode = 0;
  endtask

  initial begin
    int bad;
    void'($urandom(32'h5eed1234));
    cfg_idle_lvl = 1'b1; cfg_pol = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(strb_out == 1'b1 && rd_valid == 1'b0 && done == 1'b0, "R1 in reset",
        {strb_out, rd_valid, done}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    chk(strb_out == 1'b1, "R1 rest level", int'(strb_out), 1);
    chk(rd_valid == 1'b0, "R1 empty", int'(rd_valid), 0);
    chk(done == 1'b0, "R1 no done", int'(done), 0);

    // Directed back-to-back packets.
    run_pkt(5, 1'b1, 1'b1, 1, 1'b1, -1);
    run_pkt(4, 1'b0, 1'b0, 1, 1'b1, -1);
    run_pkt(16, 1'b0, 1'b1, 1, 1'b1, -1);
    run_pkt(1, 1'b1, 1'b0, 1, 1'b1, -1);

    // R10: zero length.
    @(posedge clk); #1;
    mon_en = 1'b0; cfg_len = 8'd0; cfg_pol = 1'b1; cfg_idle_lvl = 1'b0; dones = 0;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (strb_out !== 1'b0) bad++;
    end
    chk(bad == 0, "R10 zero length no strobe", bad, 0);
    chk(dones == 0, "R10 zero length no done", dones, 0);

    // R10: start during a packet is ignored.
    run_pkt(6, 1'b1, 1'b1, 1, 1'b1, 7);
    run_pkt(6, 1'b0, 1'b0, 2, 1'b0, 3);

    // R6 R7: stall with rest level equal to the active level.
    stall_test(1'b1, 1'b1);
    stall_test(1'b0, 1'b0);

    // Random packets, random consumer.
    for (int k = 0; k < 12; k++) begin
      run_pkt(1 + int'($urandom % 40), 1'($urandom % 2), 1'($urandom % 2), 2, 1'b0, -1);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule